// File: doc/BRIEF.md
# Multi-Channel Interrupt Aggregator

This block collects a vector of active-high, level-sensitive interrupt sources and sends the whole vector to several independent channels. Each channel keeps its own enable mask. The bitwise AND of the live source levels and that mask forms the channel's pending view. The OR of the pending bits, held in a register, drives one interrupt line per channel. No priority encoding and no vector generation take place. Software reads a channel's pending word and scans the set bits itself.

A small memory-mapped register port gives access to the channels:
- Channel n has its enable register at byte address 0x10 + 0x40*n and its pending register at 0x20 + 0x40*n.
- Address bits [8:6] select the channel and bits [5:0] select the register.
- The enable register can be read and written, so software can save its value and restore it later. The pending register is read-only.

The reset input is asserted asynchronously and is expected to be released in step with the clock.

Top module: `irq_chan_aggregator`

## Requirements
- R1: After reset every enable register is zero, every `irq_out` bit is 0 and `reg_rdata` is zero.
- R2: A write to byte address 0x10 + 0x40*n loads the whole enable mask of channel n from `reg_wdata` at that clock edge. The masks of all other channels stay unchanged.
- R3: A read of address 0x10 + 0x40*n returns channel n's enable mask on `reg_rdata` after the clock edge of the read cycle.
- R4: A read of address 0x20 + 0x40*n returns the bitwise AND of `src_i` and channel n's enable mask, both taken at the clock edge of the read cycle.
- R5: `irq_out[n]` equals the OR over k of (`src_i[k]` AND enable bit k of channel n), registered once, so it is due one clock edge after the inputs change.
- R6: A write to a pending register (0x20 + 0x40*n) changes no enable mask and no output.
- R7: An address is mapped only if bits above bit 8 are zero, the channel field [8:6] is below the channel count, and bits [5:0] equal 0x10 or 0x20. Reads of unmapped addresses return zero, and writes to them change nothing.
- R8: Pending state follows the source level with no clearing write. When a source drops, its pending bit and the channel output clear by themselves. When it rises again, they set again.
- R9: Writing zero to a channel's enable register disables all of its sources. Its output still shows the old mask at the write edge and is 0 from the next edge on.
- R10: `reg_rdata` holds its last value in every cycle without a read, even while sources change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources, shared by all channels |
| reg_wr_en | input | 1 | Register write strobe for this cycle |
| reg_rd_en | input | 1 | Register read strobe for this cycle |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| irq_out | output | NUM_CH | One registered interrupt line per channel |

## Verification
The timing of each result is as follows:
- A change on `src_i` or on an enable mask reaches `irq_out` at the next rising edge, so the output lags its inputs by exactly one edge.
- Read data appears at the edge that ends the read cycle and then holds.
- An enable write takes effect at its own edge. The output therefore still reflects the old mask at that edge and the new mask one edge later.

The bench drives every input on the falling edge and compares outputs at the next falling edge against a behavioural model updated on each rising edge. The directed checks sample exactly one or two falling edges after the stimulus, as the timing above requires.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

  // Register map geometry: fixed because software decodes it.
  localparam int unsigned OFS_W      = 6;   // register select bits [5:0]
  localparam int unsigned CH_LSB     = 6;   // channel field starts at bit 6
  localparam int unsigned CH_FIELD_W = 3;   // channel field bits [8:6]

  localparam logic [OFS_W-1:0] ENABLE_OFS  = 6'h10;
  localparam logic [OFS_W-1:0] PENDING_OFS = 6'h20;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_PENDING = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/irq_agg_decode.sv
`timescale 1ns/1ps
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NUM_CH = 8
) (
  input  logic [ADDR_W-1:0]     addr,
  output reg_sel_e              sel,
  output logic [CH_FIELD_W-1:0] ch_idx
);

  localparam int unsigned TOP_LSB = CH_LSB + CH_FIELD_W;

  logic [OFS_W-1:0] ofs;
  logic             hi_clear;
  logic             ch_ok;

  always_comb begin
    ofs      = addr[OFS_W-1:0];
    ch_idx   = addr[TOP_LSB-1:CH_LSB];
    hi_clear = ((addr >> TOP_LSB) == '0);
    ch_ok    = (int'(ch_idx) < int'(NUM_CH));
    sel      = SEL_NONE;
    if (hi_clear && ch_ok) begin
      if (ofs == ENABLE_OFS) begin
        sel = SEL_ENABLE;
      end else if (ofs == PENDING_OFS) begin
        sel = SEL_PENDING;
      end
    end
  end

endmodule

// File: rtl/irq_agg_channel.sv
`timescale 1ns/1ps
module irq_agg_channel #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               wr_stb,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq_q
);

  logic [NUM_SRC-1:0] en_d;
  logic               irq_d;

  // Next-state logic
  always_comb begin
    en_d  = wr_data;
    pend  = src_lvl & en_q;
    irq_d = |pend;
  end

  // Mask register, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_stb) begin
      en_q <= en_d;
    end
  end

  // Output register: removes glitches from the OR tree
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/irq_agg_readback.sv
`timescale 1ns/1ps
module irq_agg_readback
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  reg_sel_e                  sel,
  input  logic [CH_FIELD_W-1:0]     ch_idx,
  input  logic [NUM_CH*NUM_SRC-1:0] en_flat,
  input  logic [NUM_CH*NUM_SRC-1:0] pend_flat,
  output logic [DATA_W-1:0]         rdata_q
);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (ch_idx == CH_FIELD_W'(c)) begin
        case (sel)
          SEL_ENABLE:  rdata_d[NUM_SRC-1:0] = en_flat[c*NUM_SRC +: NUM_SRC];
          SEL_PENDING: rdata_d[NUM_SRC-1:0] = pend_flat[c*NUM_SRC +: NUM_SRC];
          default:     rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_chan_aggregator.sv
`timescale 1ns/1ps
module irq_chan_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0]  irq_out
);

  localparam int unsigned FLAT_W = NUM_CH * NUM_SRC;

  reg_sel_e              sel;
  logic [CH_FIELD_W-1:0] ch_idx;
  logic [FLAT_W-1:0]     en_flat;
  logic [FLAT_W-1:0]     pend_flat;

  irq_agg_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
  ) decode_i (
    .addr   (reg_addr),
    .sel    (sel),
    .ch_idx (ch_idx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_stb;
    assign wr_stb = reg_wr_en && (sel == SEL_ENABLE) && (ch_idx == CH_FIELD_W'(c));

    irq_agg_channel #(
      .NUM_SRC (NUM_SRC)
    ) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_lvl (src_i),
      .wr_stb  (wr_stb),
      .wr_data (reg_wdata[NUM_SRC-1:0]),
      .en_q    (en_flat[c*NUM_SRC +: NUM_SRC]),
      .pend    (pend_flat[c*NUM_SRC +: NUM_SRC]),
      .irq_q   (irq_out[c])
    );
  end

  irq_agg_readback #(
    .NUM_CH  (NUM_CH),
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) readback_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (reg_rd_en),
    .sel       (sel),
    .ch_idx    (ch_idx),
    .en_flat   (en_flat),
    .pend_flat (pend_flat),
    .rdata_q   (reg_rdata)
  );

endmodule

// File: rtl/irq_chan_aggregator_chk.sv
`timescale 1ns/1ps
module irq_chan_aggregator_chk #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        src_i,
  input logic                      reg_wr_en,
  input logic                      reg_rd_en,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [DATA_W-1:0]         reg_wdata,
  input logic [DATA_W-1:0]         reg_rdata,
  input logic [NUM_CH-1:0]         irq_out,
  input logic [NUM_CH*NUM_SRC-1:0] en_flat
);

  // Port-level address classification
  logic in_range;
  logic hit_enable;
  logic hit_pending;
  assign in_range    = (int'(reg_addr) < int'(NUM_CH) * 64);
  assign hit_enable  = in_range && (reg_addr[5:0] == 6'h10);
  assign hit_pending = in_range && (reg_addr[5:0] == 6'h20);

  // R1: outputs low while reset is asserted
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (irq_out == '0) && (reg_rdata == '0));

  // R10: read data holds without a read
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata));

  // R6: pending-register writes leave all masks alone
  a_r6_pend_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && hit_pending) |=> $stable(en_flat));

  // R7: unmapped writes leave all masks alone
  a_r7_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !hit_enable && !hit_pending) |=> $stable(en_flat));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: enable write loads that channel's mask
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && hit_enable && (int'(reg_addr[8:6]) == c))
      |=> (en_flat[c*NUM_SRC +: NUM_SRC] == $past(reg_wdata[NUM_SRC-1:0])));

    // R5: output is the registered OR of masked sources
    a_r5_irq_reduce: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[c] == |($past(src_i) & $past(en_flat[c*NUM_SRC +: NUM_SRC])));
  end

endmodule

bind irq_chan_aggregator irq_chan_aggregator_chk #(
  .NUM_CH  (NUM_CH),
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .en_flat   (en_flat)
);

// File: tb/irq_chan_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_chan_aggregator_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic        wr_en;
  logic        rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int checks;
  int errors;
  bit done;
  bit cmp_on;

  irq_chan_aggregator dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .reg_wr_en (wr_en),
    .reg_rd_en (rd_en),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .irq_out   (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference model
  logic [31:0] m_en [8];
  logic [7:0]  m_irq;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int ai = int'(a);
    for (int c = 0; c < 8; c++) begin
      if (ai == 16 + 64 * c) return m_en[c];
      if (ai == 32 + 64 * c) return src & m_en[c];
    end
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) m_en[c] <= 32'h0;
      m_irq   <= 8'h0;
      m_rdata <= 32'h0;
    end else begin
      for (int c = 0; c < 8; c++) m_irq[c] <= |(src & m_en[c]);
      if (rd_en) m_rdata <= model_read(addr);
      if (wr_en) begin
        for (int c = 0; c < 8; c++) begin
          if (int'(addr) == 16 + 64 * c) m_en[c] <= wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk("R5 irq vs model", {24'h0, irq}, {24'h0, m_irq});
      chk("R3 R4 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b0; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    checks = 0; errors = 0; done = 1'b0; cmp_on = 1'b0;
    src = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {24'h0, irq}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rd(12'h0D0, v); chk("R1 ch3 enable after reset", v, 32'h0);

    // R2 / R3: write and read back
    wr(12'h010, 32'h0000_00F0);
    rd(12'h010, v); chk("R3 ch0 enable readback", v, 32'h0000_00F0);
    rd(12'h050, v); chk("R2 ch1 untouched", v, 32'h0);

    // R5 / R4
    drive_src(32'h0000_0010);
    chk("R5 ch0 output", {24'h0, irq}, 32'h01);
    rd(12'h020, v); chk("R4 ch0 pending", v, 32'h0000_0010);
    rd(12'h060, v); chk("R4 ch1 pending masked", v, 32'h0);

    wr(12'h150, 32'hFFFF_0000);
    drive_src(32'h8001_0010);
    chk("R5 ch0 and ch5 outputs", {24'h0, irq}, 32'h21);
    rd(12'h150, v);
    wr(12'h150, v | 32'h8);
    rd(12'h150, v); chk("R2 ch5 read-modify-write", v, 32'hFFFF_0008);
    rd(12'h010, v); chk("R2 ch0 kept", v, 32'h0000_00F0);

    // R6: pending write ignored
    wr(12'h020, 32'h0);
    rd(12'h010, v); chk("R6 ch0 enable kept", v, 32'h0000_00F0);
    chk("R6 outputs kept", {24'h0, irq}, 32'h21);
    rd(12'h020, v); chk("R6 pending unchanged", v, 32'h0000_0010);

    // R7: unmapped addresses
    rd(12'h014, v); chk("R7 read 0x014", v, 32'h0);
    rd(12'h000, v); chk("R7 read 0x000", v, 32'h0);
    rd(12'h210, v); chk("R7 read 0x210", v, 32'h0);
    rd(12'h030, v); chk("R7 read 0x030", v, 32'h0);
    wr(12'h210, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h010, v); chk("R7 ch0 enable kept", v, 32'h0000_00F0);
    rd(12'h050, v); chk("R7 ch1 enable kept", v, 32'h0);
    chk("R7 outputs kept", {24'h0, irq}, 32'h21);

    // R8: level behaviour
    drive_src(32'h0);
    chk("R8 outputs drop with source", {24'h0, irq}, 32'h0);
    rd(12'h020, v); chk("R8 pending clears itself", v, 32'h0);
    drive_src(32'h0000_0010);
    chk("R8 output returns", {24'h0, irq}, 32'h01);

    // R9: write zero disables; one edge of lag
    wr(12'h010, 32'h0);
    chk("R9 output at write edge", {24'h0, irq}, 32'h01);
    @(negedge clk);
    chk("R9 output after write edge", {24'h0, irq}, 32'h0);
    rd(12'h020, v); chk("R9 pending zero", v, 32'h0);

    // R10: read data holds
    rd(12'h150, held);
    drive_src(32'hFFFF_FFFF);
    chk("R10 rdata held", rdata, held);
    chk("R10 rdata value", held, 32'hFFFF_0008);

    // All channels
    for (int c = 0; c < 8; c++) begin
      wr(12'(16 + 64 * c), 32'h1 << (c * 4 + 1));
    end
    @(negedge clk);
    chk("R5 all outputs", {24'h0, irq}, 32'hFF);
    for (int c = 0; c < 8; c++) begin
      rd(12'(16 + 64 * c), v);
      chk("R3 per-channel readback", v, 32'h1 << (c * 4 + 1));
    end
    drive_src(32'h0000_0020);
    chk("R5 single channel selected", {24'h0, irq}, 32'h02);
    rd(12'h060, v); chk("R4 ch1 pending bit 5", v, 32'h0000_0020);

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule